// File: doc/BRIEF.md
# Keyed Flash Command Controller with Region Locks

This block is the command front end of an embedded nonvolatile memory model. Software talks to it through a small register port. It writes a 32-bit command word, sets an interrupt enable in a mode register, stages program data in a data register, and polls a status register. Every command carries a fixed key byte. The controller checks that key, the opcode and the lock state of the target, then runs a modelled busy period with a countdown before the change takes effect.

The stored state lives in flops: a small page array, one lock bit per region and a set of general-purpose bits. A lock bit is stored active-low, so an unlocked region holds a 1 and reads back as 0 in status. Errors never start a busy period. A wrong key, an unknown opcode, a bad general-purpose index or a write while busy raises a programming error. A program or erase that would touch a locked region is refused as a whole and raises a lock error.

A separate array read port follows valid/ready rules. A request is taken on a cycle where both `arr_req_valid` and `arr_req_ready` are high. The response appears one cycle later with `arr_rsp_valid`. Ready is held low only while a program or erase is running. Lock, unlock and general-purpose bit commands leave reads open, and a requester must hold its request until ready returns.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A command word takes effect only if bits 31:24 equal 0x5A. Any other key sets the programming-error flag (status bit 2) and changes no stored state.
- R2: The opcode is in bits 3:0: 0x1 program page, 0x2 lock region, 0x4 unlock region, 0x8 erase whole array, 0xB set general-purpose bit, 0xD clear general-purpose bit. Any other value sets the programming-error flag and does nothing. The page field is bits 11:8, and the region is the page number divided by 4.
- R3: The ready flag (status bit 0) drops on the edge that accepts a command. It rises exactly BUSY_CYCLES clock cycles later, on the same edge that applies the command's effect.
- R4: `irq` is high exactly when the ready flag is high and mode register bit 0 is set.
- R5: Lock and unlock act on the whole region that holds the given page. Status bit 8+r reads 1 while region r is locked.
- R6: A program to a page in a locked region, or an erase while any region is locked, is refused. It sets the lock-error flag (status bit 1), starts no busy period and leaves the array unchanged.
- R7: Erase sets every array word to 0xFFFFFFFF. Program writes the data register value, captured when the command is accepted, into the addressed page.
- R8: Set and clear act on the general-purpose bit whose index is in the page field, and that bit is reported at status bit 16+i. An index of GP_BITS or more is a programming error.
- R9: A command write while busy is ignored and sets the programming-error flag. The running command still completes as it would have.
- R10: A status read returns the error flags and then clears them. Acceptance of a valid command also clears them.
- R11: `arr_req_ready` is low only while a program or erase is busy. An accepted array read returns the page word one cycle later with `arr_rsp_valid`.
- R12: After reset the status register reads 0x00000001 (ready set, no locks, no general-purpose bits, no errors), mode reads 0, `irq` is low and every array word reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 command, 1 mode, 2 status, 3 data |
| wr_data | input | 32 | Register write value |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read select |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Register read value |
| irq | output | 1 | Completion interrupt line |
| arr_req_valid | input | 1 | Array read request valid |
| arr_req_ready | output | 1 | Array read request ready |
| arr_req_addr | input | 4 | Array page to read |
| arr_rsp_valid | output | 1 | Array read response valid |
| arr_rsp_data | output | 32 | Array word read |

## Verification
The bench targets the edges of the busy window. It checks that `irq` is still low one cycle before the countdown ends and high on that exact cycle, which catches any off-by-one in the counter. It issues a second command inside a running unlock. A design that let that command through would set a general-purpose bit and lose the programming error. It drives program and erase at a locked region: a design that checked the lock too late, or only per page, would alter the array or drop ready. It also makes array reads during a lock, checks that ready blocks during erase, and uses region lock and unlock through non-first pages, out-of-range general-purpose indices and read-to-clear of the error flags.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_KEY = 8'h5A;

  typedef enum logic [3:0] {
    OP_PROG   = 4'h1,
    OP_LOCK   = 4'h2,
    OP_UNLOCK = 4'h4,
    OP_ERASE  = 4'h8,
    OP_GP_SET = 4'hB,
    OP_GP_CLR = 4'hD
  } op_e;

  localparam logic [1:0] A_CMD    = 2'd0;
  localparam logic [1:0] A_MODE   = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;
  localparam logic [1:0] A_DATA   = 2'd3;

  localparam int STS_READY    = 0;
  localparam int STS_LOCK_ERR = 1;
  localparam int STS_PROG_ERR = 2;
  localparam int STS_LOCK_LSB = 8;
  localparam int STS_GP_LSB   = 16;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int PAGE_W  = 4,
  parameter int REGIONS = 4,
  parameter int RG_W    = 2,
  parameter int GP_BITS = 4
) (
  input  logic [31:0]        cmd,
  input  logic [REGIONS-1:0] lock_n,
  output logic               cmd_ok,
  output op_e                op,
  output logic [PAGE_W-1:0]  page,
  output logic               lock_block
);
  logic            key_ok;
  logic            known;
  logic            gp_op;
  logic            gp_ok;
  logic [RG_W-1:0] region;

  assign key_ok = (cmd[31:24] == CMD_KEY);
  assign page   = cmd[8 +: PAGE_W];
  assign region = page[PAGE_W-1 -: RG_W];
  assign gp_ok  = (int'(page) < GP_BITS);

  always_comb begin
    known = 1'b1;
    op    = OP_PROG;
    case (cmd[3:0])
      4'h1:    op = OP_PROG;
      4'h2:    op = OP_LOCK;
      4'h4:    op = OP_UNLOCK;
      4'h8:    op = OP_ERASE;
      4'hB:    op = OP_GP_SET;
      4'hD:    op = OP_GP_CLR;
      default: known = 1'b0;
    endcase
  end

  assign gp_op = (op == OP_GP_SET) || (op == OP_GP_CLR);

  always_comb begin
    case (op)
      OP_PROG:  lock_block = !lock_n[region];
      OP_ERASE: lock_block = !(&lock_n);
      default:  lock_block = 1'b0;
    endcase
  end

  assign cmd_ok = key_ok && known && (!gp_op || gp_ok);
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD);
  assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/flash_nvm_store.sv
module flash_nvm_store
  import flash_cmd_pkg::*;
#(
  parameter int PAGES   = 16,
  parameter int PAGE_W  = 4,
  parameter int REGIONS = 4,
  parameter int RG_W    = 2,
  parameter int GP_BITS = 4,
  parameter int GP_W    = 2,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               apply,
  input  op_e                op,
  input  logic [PAGE_W-1:0]  page,
  input  logic [DW-1:0]      wdata,
  output logic [REGIONS-1:0] lock_n,
  output logic [GP_BITS-1:0] gp,
  input  logic               req_take,
  input  logic [PAGE_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_data
);
  logic [PAGES-1:0][DW-1:0] mem;
  logic [PAGES-1:0]         prog_hit;
  logic [REGIONS-1:0]       rg_hit;
  logic [GP_BITS-1:0]       gp_hit;

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    assign prog_hit[p] = apply && (op == OP_PROG) && (page == PAGE_W'(p));
  end
  for (genvar r = 0; r < REGIONS; r++) begin : g_region
    assign rg_hit[r] = apply && (page[PAGE_W-1 -: RG_W] == RG_W'(r));
  end
  for (genvar g = 0; g < GP_BITS; g++) begin : g_gp
    assign gp_hit[g] = apply && (page[GP_W-1:0] == GP_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '1;
    end else if (apply && op == OP_ERASE) begin
      mem <= '1;
    end else begin
      for (int p = 0; p < PAGES; p++)
        if (prog_hit[p]) mem[p] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_n <= '1;
      gp     <= '0;
    end else begin
      for (int r = 0; r < REGIONS; r++) begin
        if (rg_hit[r] && op == OP_LOCK)   lock_n[r] <= 1'b0;
        if (rg_hit[r] && op == OP_UNLOCK) lock_n[r] <= 1'b1;
      end
      for (int g = 0; g < GP_BITS; g++) begin
        if (gp_hit[g] && op == OP_GP_SET) gp[g] <= 1'b1;
        if (gp_hit[g] && op == OP_GP_CLR) gp[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_take;
      if (req_take) rsp_data <= mem[req_addr];
    end
  end

  assert_lock_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(lock_n));
  assert_gp_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(gp));
  assert_mem_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(mem));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int PAGES            = 16,
  parameter int PAGES_PER_REGION = 4,
  parameter int GP_BITS          = 4,
  parameter int BUSY_CYCLES      = 8,
  localparam int PAGE_W  = $clog2(PAGES),
  localparam int REGIONS = PAGES / PAGES_PER_REGION,
  localparam int RG_W    = $clog2(REGIONS),
  localparam int GP_W    = $clog2(GP_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              irq,
  input  logic              arr_req_valid,
  output logic              arr_req_ready,
  input  logic [PAGE_W-1:0] arr_req_addr,
  output logic              arr_rsp_valid,
  output logic [31:0]       arr_rsp_data
);
  logic               mode_ie;
  logic [31:0]        data_q;
  logic               ready_q, lock_err_q, prog_err_q;
  op_e                run_op;
  logic [PAGE_W-1:0]  run_page;
  logic [31:0]        run_data;

  logic               dec_ok, dec_block;
  op_e                dec_op;
  logic [PAGE_W-1:0]  dec_page;
  logic [REGIONS-1:0] lock_n;
  logic [GP_BITS-1:0] gp;
  logic               busy, done;
  logic               cmd_wr, accept, sts_rd;
  logic [31:0]        status;

  flash_cmd_decode #(
    .PAGE_W(PAGE_W), .REGIONS(REGIONS), .RG_W(RG_W), .GP_BITS(GP_BITS)
  ) u_decode (
    .cmd(wr_data), .lock_n(lock_n), .cmd_ok(dec_ok), .op(dec_op),
    .page(dec_page), .lock_block(dec_block)
  );

  flash_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .done(done)
  );

  assign arr_req_ready = !(busy && (run_op == OP_PROG || run_op == OP_ERASE));

  flash_nvm_store #(
    .PAGES(PAGES), .PAGE_W(PAGE_W), .REGIONS(REGIONS), .RG_W(RG_W),
    .GP_BITS(GP_BITS), .GP_W(GP_W), .DW(32)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .apply(done), .op(run_op), .page(run_page),
    .wdata(run_data), .lock_n(lock_n), .gp(gp),
    .req_take(arr_req_valid && arr_req_ready), .req_addr(arr_req_addr),
    .rsp_valid(arr_rsp_valid), .rsp_data(arr_rsp_data)
  );

  assign cmd_wr = wr_en && (wr_addr == A_CMD);
  assign accept = cmd_wr && !busy && dec_ok && !dec_block;
  assign sts_rd = rd_en && (rd_addr == A_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_ie    <= 1'b0;
      data_q     <= '0;
      ready_q    <= 1'b1;
      lock_err_q <= 1'b0;
      prog_err_q <= 1'b0;
      run_op     <= OP_PROG;
      run_page   <= '0;
      run_data   <= '0;
    end else begin
      if (wr_en && wr_addr == A_MODE) mode_ie <= wr_data[0];
      if (wr_en && wr_addr == A_DATA) data_q  <= wr_data;
      if (accept) begin
        ready_q  <= 1'b0;
        run_op   <= dec_op;
        run_page <= dec_page;
        run_data <= data_q;
      end else if (done) begin
        ready_q <= 1'b1;
      end
      if (sts_rd || accept) begin
        lock_err_q <= 1'b0;
        prog_err_q <= 1'b0;
      end
      if (cmd_wr && (busy || !dec_ok)) prog_err_q <= 1'b1;
      if (cmd_wr && !busy && dec_ok && dec_block) lock_err_q <= 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[STS_READY]    = ready_q;
    status[STS_LOCK_ERR] = lock_err_q;
    status[STS_PROG_ERR] = prog_err_q;
    status[STS_LOCK_LSB +: REGIONS] = ~lock_n;
    status[STS_GP_LSB +: GP_BITS]   = gp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (rd_addr)
          A_MODE:   rd_data <= {31'd0, mode_ie};
          A_STATUS: rd_data <= status;
          A_DATA:   rd_data <= data_q;
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  assign irq = ready_q && mode_ie;

  assert_busy_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready_q);
  assert_read_block_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_req_ready |-> busy);
  assert_lock_err_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_err_q) |-> !busy);
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> ($stable(run_op) && $stable(run_page)));
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int BUSY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq;
  logic        arr_req_valid = 1'b0;
  logic        arr_req_ready;
  logic [3:0]  arr_req_addr = '0;
  logic        arr_rsp_valid;
  logic [31:0] arr_rsp_data;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t rq[$];
  exp_t aq[$];

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.BUSY_CYCLES(BUSY)) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq(irq), .arr_req_valid(arr_req_valid), .arr_req_ready(arr_req_ready),
    .arr_req_addr(arr_req_addr), .arr_rsp_valid(arr_rsp_valid),
    .arr_rsp_data(arr_rsp_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd(input logic [3:0] op, input logic [3:0] pg,
                                      input logic [7:0] key = 8'h5A);
    return {key, 12'h000, pg, 4'h0, op};
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.exp = e; it.tag = tag;
    rq.push_back(it);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic arr_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.exp = e; it.tag = tag;
    aq.push_back(it);
    arr_req_valid = 1'b1; arr_req_addr = a;
    @(negedge clk);
    arr_req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_done();
    repeat (BUSY + 1) @(negedge clk);
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    exp_t it;
    if (rd_valid) begin
      if (rq.size() == 0) check(1'b0, "reg read without expectation", rd_data, 32'h0);
      else begin
        it = rq.pop_front();
        check(rd_data == it.exp, it.tag, rd_data, it.exp);
      end
    end
    if (arr_rsp_valid) begin
      if (aq.size() == 0) check(1'b0, "R11 array response without request", arr_rsp_data, 32'h0);
      else begin
        it = aq.pop_front();
        check(arr_rsp_data == it.exp, it.tag, arr_rsp_data, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check(irq == 1'b0, "R12 irq after reset", 32'(irq), 32'h0);
    reg_rd(2'd2, 32'h0000_0001, "R12 status after reset");
    reg_rd(2'd1, 32'h0, "R12 mode after reset");
    arr_rd(4'd3, 32'hFFFF_FFFF, "R12 array erased after reset");

    // R7 program with exact completion timing (R3, R4)
    reg_wr(2'd1, 32'h1);
    check(irq == 1'b1, "R4 irq with ready and enable", 32'(irq), 32'h1);
    reg_wr(2'd3, 32'h1234_5678);
    reg_wr(2'd0, cmd(4'h1, 4'd5));
    check(irq == 1'b0, "R3 ready drops on accept", 32'(irq), 32'h0);
    check(arr_req_ready == 1'b0, "R11 reads blocked during program", 32'(arr_req_ready), 32'h0);
    repeat (BUSY - 1) @(negedge clk);
    check(irq == 1'b0, "R3 still busy one cycle before end", 32'(irq), 32'h0);
    @(negedge clk);
    check(irq == 1'b1, "R3 ready after BUSY_CYCLES", 32'(irq), 32'h1);
    arr_rd(4'd5, 32'h1234_5678, "R7 programmed word");

    // R1 bad key
    reg_wr(2'd0, cmd(4'h1, 4'd6, 8'hA5));
    reg_rd(2'd2, 32'h0000_0005, "R1 bad key sets programming error");
    reg_rd(2'd2, 32'h0000_0001, "R10 status read cleared errors");
    arr_rd(4'd6, 32'hFFFF_FFFF, "R1 bad key left array alone");

    // R2 unknown opcode, then R10 clear by accept, R5 lock via page 6
    reg_wr(2'd0, cmd(4'h7, 4'd6));
    check(irq == 1'b1, "R2 unknown opcode starts no busy", 32'(irq), 32'h1);
    reg_wr(2'd0, cmd(4'h2, 4'd6));
    check(arr_req_ready == 1'b1, "R11 reads open during lock", 32'(arr_req_ready), 32'h1);
    arr_rd(4'd5, 32'h1234_5678, "R11 read during lock");
    wait_done();
    reg_rd(2'd2, 32'h0000_0201, "R5 region 1 locked, R10 error cleared by accept");

    // R6 program into locked region
    reg_wr(2'd3, 32'hDEAD_BEEF);
    reg_wr(2'd0, cmd(4'h1, 4'd7));
    check(irq == 1'b1, "R6 refused program starts no busy", 32'(irq), 32'h1);
    reg_rd(2'd2, 32'h0000_0203, "R6 lock error on program");
    arr_rd(4'd7, 32'hFFFF_FFFF, "R6 locked page unchanged");

    // R6 erase with a locked region
    reg_wr(2'd0, cmd(4'h8, 4'd0));
    check(arr_req_ready == 1'b1, "R6 refused erase starts no busy", 32'(arr_req_ready), 32'h1);
    reg_rd(2'd2, 32'h0000_0203, "R6 lock error on erase");
    arr_rd(4'd5, 32'h1234_5678, "R6 erase refused as a whole");

    // R9 write while busy during unlock (R5 via page 4)
    reg_wr(2'd0, cmd(4'h4, 4'd4));
    reg_wr(2'd0, cmd(4'hB, 4'd0));
    wait_done();
    reg_rd(2'd2, 32'h0000_0005, "R9 busy write ignored and flagged, R5 unlocked");

    // R8 general-purpose bits
    reg_wr(2'd0, cmd(4'hB, 4'd2));
    wait_done();
    reg_rd(2'd2, 32'h0004_0001, "R8 gp bit 2 set");
    reg_wr(2'd0, cmd(4'hB, 4'd5));
    reg_rd(2'd2, 32'h0004_0005, "R8 gp index out of range");
    reg_wr(2'd0, cmd(4'hD, 4'd2));
    wait_done();
    reg_rd(2'd2, 32'h0000_0001, "R8 gp bit 2 cleared");

    // R5 regions through non-first pages
    reg_wr(2'd0, cmd(4'h2, 4'd15));
    wait_done();
    reg_wr(2'd0, cmd(4'h2, 4'd2));
    wait_done();
    reg_rd(2'd2, 32'h0000_0901, "R5 regions 0 and 3 locked");
    reg_wr(2'd0, cmd(4'h4, 4'd13));
    wait_done();
    reg_rd(2'd2, 32'h0000_0101, "R5 region 3 unlocked via page 13");
    reg_wr(2'd0, cmd(4'h4, 4'd0));
    wait_done();

    // R7 erase
    reg_wr(2'd0, cmd(4'h8, 4'd0));
    check(arr_req_ready == 1'b0, "R11 reads blocked during erase", 32'(arr_req_ready), 32'h0);
    wait_done();
    arr_rd(4'd5, 32'hFFFF_FFFF, "R7 erase restored all ones");
    reg_rd(2'd2, 32'h0000_0001, "R7 status after erase");

    // R4 disable interrupt
    reg_wr(2'd1, 32'h0);
    check(irq == 1'b0, "R4 irq off when disabled", 32'(irq), 32'h0);
    reg_rd(2'd1, 32'h0, "R4 mode reads back 0");

    repeat (3) @(negedge clk);
    check(rq.size() == 0 && aq.size() == 0, "R11 all responses seen",
          32'(rq.size() + aq.size()), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule